// File: doc/BRIEF.md
# Rotate Through Carry Register Unit

This unit executes one byte instruction: it rotates an operand from a banked register file one place to the left, with the carry flag acting as a ninth bit. The old carry enters result bit 0 and operand bit 7 becomes the new carry. The result goes either to the working register or back to the file location it was read from. The carry, negative and zero flags are refreshed afterwards.

The effective 12-bit data address comes from the 8-bit field of the instruction word. One instruction bit chooses between two ways of forming it. The first uses the 4-bit bank select input as the upper nibble. The second uses a fixed access window, in which low field values reach bank 0 and high field values reach the top 160 bytes of the data space.

Every instruction occupies one instruction cycle of four clock ticks. The phase input marks each tick:
- 0: decode
- 1: read
- 2: process
- 3: write

An extended addressing mode can be enabled. The unit does not implement it. It detects instructions that would use it, raises a flag for them and executes nothing else for them.

Top module: `rtc_unit`

## Requirements
- R1: An instruction is accepted only when `instrValid` is high during phase 0 and `instrWord[15:10]` equals 6'b001101. Any other word causes no read strobe, no write strobe and no change of the working register or flags.
- R2: The result is `{operand[6:0], carry}`, and the carry becomes `operand[7]`. For example, operand 8'hE6 with carry 0 gives 8'hCC with carry 1.
- R3: When `instrWord[9]` (destination bit) is 0, the working register takes the result, and no file write occurs.
- R4: When `instrWord[9]` is 1, the result is written to the same address that was read, and the working register is unchanged.
- R5: When `instrWord[8]` (bank mode bit) is 1, the address is `{bsr, instrWord[7:0]}`.
- R6: When `instrWord[8]` is 0, a field value below 8'h60 addresses 12'h000 plus the field. A value of 8'h60 or above addresses 12'hF00 plus the field.
- R7: After the operation, the negative flag equals result bit 7, and the zero flag is set exactly when the 8-bit result is 0.
- R8: With `extEnable` high, bank mode bit 0 and field at most 8'h5F, the instruction is an indexed one. `indexedHit` is high during phases 1 to 3, and there are no read, no write and no change of the working register or flags.
- R9: `rfRdEn` is high only in phase 1 and `rfWrEn` only in phase 3. The working register and the flags change only on the clock edge that ends phase 3.
- R10: After reset, the working register and all three flags are 0, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phase | input | 2 | Quarter-phase of the instruction cycle (0 decode … 3 write) |
| instrValid | input | 1 | Instruction word valid in phase 0 |
| instrWord | input | 16 | Instruction word |
| extEnable | input | 1 | Extended indexed addressing enabled |
| bsr | input | 4 | Bank select value, held through phases 1 to 3 |
| rfRdData | input | 8 | Register file read data (combinational from rfAddr) |
| rfAddr | output | 12 | Register file address |
| rfRdEn | output | 1 | Register file read strobe |
| rfWrEn | output | 1 | Register file write strobe |
| rfWrData | output | 8 | Register file write data |
| wReg | output | 8 | Working register |
| carryFlag | output | 1 | Carry flag |
| negFlag | output | 1 | Negative flag |
| zeroFlag | output | 1 | Zero flag |
| indexedHit | output | 1 | Indexed addressing instruction detected |

## Verification
The assertions check the following on every cycle:
- strobes appear only in their own phase;
- the working register and flags never move outside the phase-3 edge;
- a written byte carries the old carry in bit 0;
- the negative and zero flags follow each written result;
- an indexed instruction never touches the file.

Some behaviour only the bench scenarios can show. This covers the exact address formed at the access-window boundary 8'h5F/8'h60 and under bank select, and the rotated values, including the worked example. It also covers the carry chaining over a run of back-to-back instructions, and the silence of the unit for foreign opcodes and for an idle valid line.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    PH_DECODE = 2'd0,
    PH_READ   = 2'd1,
    PH_PROC   = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  // Strobes from control to datapath, one per micro-step.
  typedef struct packed {
    logic rdEn;
    logic latchRes;
    logic wrFile;
    logic wrW;
    logic wrFlags;
  } rtcStrobes_t;

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 8,
  parameter int OPC_W   = 6,
  parameter logic [OPC_W-1:0] OPCODE = 6'b001101,
  parameter logic [DATA_W-1:0] SPLIT = 8'h60
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         phase,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               extEnable,
  output rtcStrobes_t        strobes,
  output logic               destFile,
  output logic               bankSel,
  output logic [DATA_W-1:0]  fieldAddr,
  output logic               indexedHit
);

  localparam int D_BIT = DATA_W + 1;
  localparam int A_BIT = DATA_W;

  logic              busy;
  logic              idxReg;
  logic              opMatch;
  logic              isIndexed;
  logic              runOp;
  logic [OPC_W-1:0]  opField;

  assign opField   = instrWord[INSTR_W-1 -: OPC_W];
  assign opMatch   = instrValid && (phase == PH_DECODE) && (opField == OPCODE);
  assign isIndexed = extEnable && !instrWord[A_BIT] && (instrWord[DATA_W-1:0] < SPLIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      idxReg    <= 1'b0;
      destFile  <= 1'b0;
      bankSel   <= 1'b0;
      fieldAddr <= '0;
    end else if (opMatch) begin
      busy      <= 1'b1;
      idxReg    <= isIndexed;
      destFile  <= instrWord[D_BIT];
      bankSel   <= instrWord[A_BIT];
      fieldAddr <= instrWord[DATA_W-1:0];
    end else if (phase == PH_WRITE) begin
      busy   <= 1'b0;
      idxReg <= 1'b0;
    end
  end

  assign runOp      = busy && !idxReg;
  assign indexedHit = busy && idxReg;

  always_comb begin
    strobes          = '0;
    strobes.rdEn     = runOp && (phase == PH_READ);
    strobes.latchRes = runOp && (phase == PH_PROC);
    strobes.wrFile   = runOp && (phase == PH_WRITE) && destFile;
    strobes.wrW      = runOp && (phase == PH_WRITE) && !destFile;
    strobes.wrFlags  = runOp && (phase == PH_WRITE);
  end

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  parameter logic [DATA_W-1:0] SPLIT = 8'h60
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rtcStrobes_t              strobes,
  input  logic                     destFile,
  input  logic                     bankSel,
  input  logic [DATA_W-1:0]        fieldAddr,
  input  logic [ADDR_W-DATA_W-1:0] bsr,
  input  logic [DATA_W-1:0]        rfRdData,
  output logic [ADDR_W-1:0]        rfAddr,
  output logic                     rfRdEn,
  output logic                     rfWrEn,
  output logic [DATA_W-1:0]        rfWrData,
  output logic [DATA_W-1:0]        wOut,
  output logic                     carryOut,
  output logic                     negOut,
  output logic                     zeroOut
);

  localparam int BANK_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] opReg;
  logic [DATA_W-1:0] resReg;
  logic              carryNew;
  logic [DATA_W-1:0] rotNext;

  // Address: bank select, or the split access window.
  always_comb begin
    if (bankSel)
      rfAddr = {bsr, fieldAddr};
    else if (fieldAddr < SPLIT)
      rfAddr = {{BANK_W{1'b0}}, fieldAddr};
    else
      rfAddr = {{BANK_W{1'b1}}, fieldAddr};
  end

  // Rotate left by one through carry.
  assign rotNext[0] = carryOut;
  for (genvar i = 1; i < DATA_W; i++) begin : g_rot
    assign rotNext[i] = opReg[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg    <= '0;
      resReg   <= '0;
      carryNew <= 1'b0;
      wOut     <= '0;
      carryOut <= 1'b0;
      negOut   <= 1'b0;
      zeroOut  <= 1'b0;
    end else begin
      if (strobes.rdEn)
        opReg <= rfRdData;
      if (strobes.latchRes) begin
        resReg   <= rotNext;
        carryNew <= opReg[DATA_W-1];
      end
      if (strobes.wrW)
        wOut <= resReg;
      if (strobes.wrFlags) begin
        carryOut <= carryNew;
        negOut   <= resReg[DATA_W-1];
        zeroOut  <= (resReg == '0);
      end
    end
  end

  assign rfRdEn   = strobes.rdEn;
  assign rfWrEn   = strobes.wrFile && destFile;
  assign rfWrData = resReg;

endmodule

// File: rtl/rtc_unit.sv
module rtc_unit
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  parameter int INSTR_W = 16,
  parameter logic [DATA_W-1:0] SPLIT = 8'h60
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               phase,
  input  logic                     instrValid,
  input  logic [INSTR_W-1:0]       instrWord,
  input  logic                     extEnable,
  input  logic [ADDR_W-DATA_W-1:0] bsr,
  input  logic [DATA_W-1:0]        rfRdData,
  output logic [ADDR_W-1:0]        rfAddr,
  output logic                     rfRdEn,
  output logic                     rfWrEn,
  output logic [DATA_W-1:0]        rfWrData,
  output logic [DATA_W-1:0]        wReg,
  output logic                     carryFlag,
  output logic                     negFlag,
  output logic                     zeroFlag,
  output logic                     indexedHit
);

  rtcStrobes_t       strobes;
  logic              destFile;
  logic              bankSel;
  logic [DATA_W-1:0] fieldAddr;

  rtc_ctrl #(
    .INSTR_W(INSTR_W),
    .DATA_W (DATA_W),
    .SPLIT  (SPLIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .phase     (phase),
    .instrValid(instrValid),
    .instrWord (instrWord),
    .extEnable (extEnable),
    .strobes   (strobes),
    .destFile  (destFile),
    .bankSel   (bankSel),
    .fieldAddr (fieldAddr),
    .indexedHit(indexedHit)
  );

  rtc_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .SPLIT (SPLIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .destFile (destFile),
    .bankSel  (bankSel),
    .fieldAddr(fieldAddr),
    .bsr      (bsr),
    .rfRdData (rfRdData),
    .rfAddr   (rfAddr),
    .rfRdEn   (rfRdEn),
    .rfWrEn   (rfWrEn),
    .rfWrData (rfWrData),
    .wOut     (wReg),
    .carryOut (carryFlag),
    .negOut   (negFlag),
    .zeroOut  (zeroFlag)
  );

endmodule

// File: rtl/rtc_unit_chk.sv
module rtc_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        phase,
  input logic              rfRdEn,
  input logic              rfWrEn,
  input logic [DATA_W-1:0] rfWrData,
  input logic [DATA_W-1:0] wReg,
  input logic              carryFlag,
  input logic              negFlag,
  input logic              zeroFlag,
  input logic              indexedHit
);

  p_rd_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    rfRdEn |-> (phase == 2'd1));

  p_wr_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (phase == 2'd3));

  p_w_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd3) |=> $stable(wReg));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd3) |=> $stable({carryFlag, negFlag, zeroFlag}));

  p_carry_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrData[0] == carryFlag));

  p_file_dest_r4: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> $stable(wReg));

  p_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> (negFlag == $past(rfWrData[DATA_W-1])) &&
               (zeroFlag == ($past(rfWrData) == '0)));

  p_idx_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    indexedHit |-> (!rfRdEn && !rfWrEn));

endmodule

bind rtc_unit rtc_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .phase     (phase),
  .rfRdEn    (rfRdEn),
  .rfWrEn    (rfWrEn),
  .rfWrData  (rfWrData),
  .wReg      (wReg),
  .carryFlag (carryFlag),
  .negFlag   (negFlag),
  .zeroFlag  (zeroFlag),
  .indexedHit(indexedHit)
);

// File: tb/rtc_unit_tb.sv
module rtc_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  phase = 2'd0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        extEnable = 1'b0;
  logic [3:0]  bsr = '0;
  logic [7:0]  rfRdData;
  logic [11:0] rfAddr;
  logic        rfRdEn, rfWrEn;
  logic [7:0]  rfWrData, wReg;
  logic        carryFlag, negFlag, zeroFlag, indexedHit;

  logic [7:0]  mem [4096];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit         exec;
    bit         idx;
    bit         d;
    logic [11:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  w;
    bit         c, n, z;
    string      tag;
  } item_t;

  item_t q[$];

  logic [7:0] expW = '0;
  bit expC = 0, expN = 0, expZ = 0;

  always #5 clk = ~clk;

  rtc_unit u_dut (
    .clk(clk), .rstN(rstN), .phase(phase), .instrValid(instrValid),
    .instrWord(instrWord), .extEnable(extEnable), .bsr(bsr),
    .rfRdData(rfRdData), .rfAddr(rfAddr), .rfRdEn(rfRdEn), .rfWrEn(rfWrEn),
    .rfWrData(rfWrData), .wReg(wReg), .carryFlag(carryFlag),
    .negFlag(negFlag), .zeroFlag(zeroFlag), .indexedHit(indexedHit)
  );

  assign rfRdData = mem[rfAddr];

  always @(posedge clk) begin
    if (!rstN) phase <= 2'd0;
    else       phase <= phase + 2'd1;
    if (rfWrEn) mem[rfAddr] <= rfWrData;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected outcome and queues it.
  task automatic issue(input logic [15:0] iw, input bit valid, input bit ext,
                       input logic [3:0] bank, input string tag);
    item_t it;
    bit match, d, a;
    logic [7:0] f, op, res;
    @(negedge clk);
    while (phase != 2'd0) @(negedge clk);
    #1;
    d = iw[9]; a = iw[8]; f = iw[7:0];
    match = valid && (iw[15:10] == 6'b001101);
    it.idx  = match && ext && !a && (f < 8'h60);
    it.exec = match && !it.idx;
    it.d = d;
    it.tag = tag;
    if (a)            it.addr = {bank, f};
    else if (f < 8'h60) it.addr = {4'h0, f};
    else              it.addr = {4'hF, f};
    it.wdata = '0;
    if (it.exec) begin
      op  = mem[it.addr];
      res = {op[6:0], expC};
      it.wdata = res;
      if (!d) expW = res;
      expC = op[7];
      expN = res[7];
      expZ = (res == 8'h00);
    end
    it.w = expW; it.c = expC; it.n = expN; it.z = expZ;
    q.push_back(it);
    instrWord  = iw;
    instrValid = valid;
    extEnable  = ext;
    bsr        = bank;
    @(negedge clk);
    #1 instrValid = 1'b0;
  endtask

  // Monitor: follows each queued instruction through its phases.
  initial begin
    bit active = 0;
    item_t it;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (phase == 2'd1 && q.size() > 0) begin
          active = 1;
          it = q[0];
          check(rfRdEn == it.exec, {it.tag, " R9 read strobe"}, rfRdEn, it.exec);
          check(indexedHit == it.idx, {it.tag, " R8 indexedHit"}, indexedHit, it.idx);
          if (it.exec)
            check(rfAddr == it.addr, {it.tag, " R5/R6 address"}, rfAddr, it.addr);
        end else if (phase == 2'd3 && active) begin
          check(rfWrEn == (it.exec && it.d), {it.tag, " R3/R4 write strobe"},
                rfWrEn, it.exec && it.d);
          check(indexedHit == it.idx, {it.tag, " R8 indexedHit Q4"}, indexedHit, it.idx);
          if (it.exec && it.d) begin
            check(rfAddr == it.addr, {it.tag, " R4 write address"}, rfAddr, it.addr);
            check(rfWrData == it.wdata, {it.tag, " R2 write data"}, rfWrData, it.wdata);
          end
        end else if (phase == 2'd0 && active) begin
          check(wReg == it.w, {it.tag, " R3 working reg"}, wReg, it.w);
          check(carryFlag == it.c, {it.tag, " R2 carry"}, carryFlag, it.c);
          check(negFlag == it.n, {it.tag, " R7 negative"}, negFlag, it.n);
          check(zeroFlag == it.z, {it.tag, " R7 zero"}, zeroFlag, it.z);
          void'(q.pop_front());
          active = 0;
        end
      end
    end
  end

  function automatic logic [15:0] mk(input bit d, input bit a, input logic [7:0] f);
    return {6'b001101, d, a, f};
  endfunction

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37) ^ 8'(i >> 4);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(wReg == 8'h00, "R10 wReg", wReg, 0);
    check({carryFlag, negFlag, zeroFlag} == 3'b000, "R10 flags",
          {carryFlag, negFlag, zeroFlag}, 0);
    check(!rfRdEn && !rfWrEn, "R10 strobes", {rfRdEn, rfWrEn}, 0);
    @(negedge clk) rstN = 1'b1;

    // R2 worked case, R3 destination W, R6 low window
    mem[12'h025] = 8'hE6;
    issue(mk(0, 0, 8'h25), 1, 0, 4'h0, "R2 worked");
    // R4 file write, R5 bank select (carry now 1)
    mem[12'h310] = 8'h01;
    issue(mk(1, 1, 8'h10), 1, 0, 4'h3, "R5 bank");
    // R6 high window, R7 zero result
    mem[12'hF80] = 8'h80;
    issue(mk(1, 0, 8'h80), 1, 0, 4'h7, "R6 high zero");
    // R6 boundaries
    issue(mk(1, 0, 8'h5F), 1, 0, 4'h2, "R6 edge 5F");
    issue(mk(0, 0, 8'h60), 1, 0, 4'h2, "R6 edge 60");
    // R1 foreign opcode and idle valid
    issue(16'h3A25, 1, 0, 4'h0, "R1 other opcode");
    issue(mk(1, 0, 8'h25), 0, 0, 4'h0, "R1 not valid");
    // R8 indexed detection and its neighbours
    issue(mk(1, 0, 8'h5F), 1, 1, 4'h0, "R8 indexed");
    issue(mk(0, 0, 8'h00), 1, 1, 4'h0, "R8 indexed zero");
    issue(mk(1, 0, 8'h60), 1, 1, 4'h0, "R8 ext high");
    issue(mk(1, 1, 8'h10), 1, 1, 4'h5, "R8 ext banked");
    // R2/R9 back-to-back chain with varied operands
    for (int k = 0; k < 24; k++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      issue(mk(lfsr[9], lfsr[8], lfsr[7:0]), 1, lfsr[20] & lfsr[21], lfsr[15:12], "R2 chain");
    end
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R9 queue drained", q.size(), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule